// File: doc/BRIEF.md
# Interrupt Status Aggregator with Output Routing

This block gathers level-type interrupt requests from several hardware sources, plus a handful of software-raised test bits, into a single latched status word. Eight routing registers each hold a mask over that word, and each of the eight interrupt outputs is raised whenever its mask selects at least one set status bit. Software acknowledges pending interrupts by writing the status register. The acknowledge write clears every bit for which the written word holds a zero.

The hardware sources occupy the low status bits. A dedicated input carries the combined interrupt of a GPIO controller into its own reserved bit. The software test bits sit in the top nibble. They are raised by writing ones into the control register. This allows the whole path from status to outputs to be exercised without any external source. Access goes through a simple 32-bit word-addressed port with one write strobe. Read data is registered.

Top module: `irq_agg_top`

## Requirements
- R1: After a synchronous reset the status word, all eight routing registers, every bit of `irq_out` and `bus_rdata` are zero.
- R2: A high level on `hw_irq[i]` sets status bit i, and a high level on `gpio_irq` sets status bit 15. Each bit is visible in a read issued in the cycle after the input was sampled.
- R3: A set status bit stays set after its source falls, until an acknowledge write clears it.
- R4: A write to address 1 (status) clears each status bit whose written bit is 0 and leaves each bit written as 1 unchanged. Writing zero clears the whole word.
- R5: An acknowledge cannot remove a hardware bit while its input is still high. Once the input has fallen the bit stays latched, and the next acknowledge removes it.
- R6: Writing ones to bits 31:28 of address 0 (control) sets the matching software status bits. All other bits of that write are ignored, and address 0 reads as zero.
- R7: Status bits 8 to 14 and 16 to 27 always read as zero, whatever the sources or writes do.
- R8: Routing register k (address 2+k, k = 0..7) stores a full 32-bit word that reads back unchanged.
- R9: `irq_out[k]` equals the OR of (status AND routing register k). It takes its new value at the same clock edge that updates the status word or the routing register.
- R10: Clearing a routing bit lowers the corresponding output at the edge that takes the write, even while the status bit stays set.
- R11: `bus_rdata` is registered. It shows, one edge after `bus_addr` is presented, the addressed register as it stood before that edge. Addresses 10 to 15 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Word address of the register port |
| bus_wr | input | 1 | Write strobe, sampled each edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| hw_irq | input | 8 | Level interrupt requests from hardware sources |
| gpio_irq | input | 1 | Combined interrupt of the GPIO controller |
| irq_out | output | 8 | Routed interrupt outputs |

## Verification
Every result of this block is due exactly one clock edge after the stimulus is sampled. Status bits, routing registers and outputs all move at the edge that samples a source level or a write. Read data moves at the edge that samples the address. The bench therefore drives inputs on the falling edge and samples outputs on the following falling edge, half a cycle after the edge that produced them. The 256-step sweep checks `irq_out` in the first half-cycle after the combined source and software pulse. A late or early output is caught there rather than being hidden by a settled value.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  // Register word addresses (decoded by the top; bench relies on them)
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_STAT = 1;
  localparam int ADDR_CFG0 = 2;

  typedef enum logic [1:0] {
    REG_CTRL,
    REG_STAT,
    REG_CFG,
    REG_NONE
  } reg_kind_e;

  function automatic reg_kind_e decode_kind(input int addr, input int n_cfg);
    if (addr == ADDR_CTRL)                                    return REG_CTRL;
    else if (addr == ADDR_STAT)                               return REG_STAT;
    else if (addr >= ADDR_CFG0 && addr < ADDR_CFG0 + n_cfg)   return REG_CFG;
    else                                                      return REG_NONE;
  endfunction

endpackage

// File: rtl/irq_agg_status.sv
module irq_agg_status #(
  parameter int          DATA_W     = 32,
  parameter logic [31:0] VALID_MASK = 32'hF000_80FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] hw_vec,    // hardware levels already at their bit positions
  input  logic [DATA_W-1:0] sw_set,    // software bits to raise this cycle
  input  logic              ack_wr,    // acknowledge write strobe
  input  logic [DATA_W-1:0] ack_keep,  // bits written as 1 survive the acknowledge
  output logic [DATA_W-1:0] stat_q,
  output logic [DATA_W-1:0] stat_d
);

  localparam logic [DATA_W-1:0] VMASK = VALID_MASK[DATA_W-1:0];

  logic [DATA_W-1:0] kept;

  always_comb begin
    kept   = ack_wr ? (stat_q & ack_keep) : stat_q;
    stat_d = (kept | hw_vec | sw_set) & VMASK;
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= stat_d;
  end

  // R3: without an acknowledge no set bit is lost
  a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
    !ack_wr |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R2 / R5: an active hardware level is always present next cycle, even across an acknowledge
  a_r5_hw_level_wins: assert property (@(posedge clk) disable iff (rst)
    (hw_vec != '0) |=> ((stat_q & $past(hw_vec & VMASK)) == $past(hw_vec & VMASK)));

  // R6: software bits appear the cycle after the control write
  a_r6_sw_sets: assert property (@(posedge clk) disable iff (rst)
    (sw_set != '0) |=> ((stat_q & $past(sw_set & VMASK)) == $past(sw_set & VMASK)));

  // R4: acknowledging with zero and no sources leaves an empty word
  a_r4_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (ack_wr && ack_keep == '0 && hw_vec == '0 && sw_set == '0) |=> (stat_q == '0));

  // R7: reserved positions never hold a one
  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    ((stat_q & ~VMASK) == '0));

endmodule

// File: rtl/irq_agg_route.sv
module irq_agg_route #(
  parameter int DATA_W = 32,
  parameter int N_OUT  = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [N_OUT-1:0]              cfg_we,
  input  logic [DATA_W-1:0]             cfg_wdata,
  input  logic [DATA_W-1:0]             stat_q,
  input  logic [DATA_W-1:0]             stat_d,
  output logic [N_OUT-1:0][DATA_W-1:0]  cfg_q,
  output logic [N_OUT-1:0]              irq_q
);

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    logic [DATA_W-1:0] cfg_d;

    always_comb cfg_d = cfg_we[k] ? cfg_wdata : cfg_q[k];

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[k] <= '0;
        irq_q[k] <= 1'b0;
      end else begin
        cfg_q[k] <= cfg_d;
        irq_q[k] <= |(stat_d & cfg_d);   // next-state terms: output moves with the registers
      end
    end

    // R9: registered output always agrees with the registered status and mask
    a_r9_out_matches: assert property (@(posedge clk) disable iff (rst)
      irq_q[k] == |(stat_q & cfg_q[k]));

    // R10: an all-zero mask write silences the output at once
    a_r10_mask_off: assert property (@(posedge clk) disable iff (rst)
      (cfg_we[k] && cfg_wdata == '0) |=> !irq_q[k]);
  end

endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int N_OUT    = 8,
  parameter int N_HW     = 8,
  parameter int GPIO_POS = 15,
  parameter int SW_LSB   = 28,
  parameter int N_SW     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_HW-1:0]   hw_irq,
  input  logic              gpio_irq,
  output logic [N_OUT-1:0]  irq_out
);

  localparam int IDX_W = (N_OUT > 1) ? $clog2(N_OUT) : 1;
  localparam logic [DATA_W-1:0] HW_MASK   = DATA_W'((64'd1 << N_HW) - 64'd1);
  localparam logic [DATA_W-1:0] GPIO_MASK = DATA_W'(64'd1 << GPIO_POS);
  localparam logic [DATA_W-1:0] SW_MASK   = DATA_W'(((64'd1 << N_SW) - 64'd1) << SW_LSB);
  localparam logic [DATA_W-1:0] VALID     = HW_MASK | GPIO_MASK | SW_MASK;

  reg_kind_e         kind;
  logic [DATA_W-1:0] hw_vec, sw_set, stat_q, stat_d;
  logic              ack_wr;
  logic [N_OUT-1:0]  cfg_we;
  logic [N_OUT-1:0][DATA_W-1:0] cfg_q;
  logic [ADDR_W-1:0] cfg_off;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    kind    = decode_kind(int'(bus_addr), N_OUT);
    hw_vec  = (DATA_W'(hw_irq) & HW_MASK) | (gpio_irq ? GPIO_MASK : '0);
    sw_set  = (bus_wr && kind == REG_CTRL) ? (bus_wdata & SW_MASK) : '0;
    ack_wr  = bus_wr && kind == REG_STAT;
    cfg_off = bus_addr - ADDR_W'(ADDR_CFG0);
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_we
    assign cfg_we[k] = bus_wr && (bus_addr == ADDR_W'(ADDR_CFG0 + k));
  end

  irq_agg_status #(.DATA_W(DATA_W), .VALID_MASK(32'(VALID))) u_status (
    .clk(clk), .rst(rst), .hw_vec(hw_vec), .sw_set(sw_set),
    .ack_wr(ack_wr), .ack_keep(bus_wdata), .stat_q(stat_q), .stat_d(stat_d)
  );

  irq_agg_route #(.DATA_W(DATA_W), .N_OUT(N_OUT)) u_route (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(bus_wdata),
    .stat_q(stat_q), .stat_d(stat_d), .cfg_q(cfg_q), .irq_q(irq_out)
  );

  always_comb begin
    unique case (kind)
      REG_STAT: rd_mux = stat_q;
      REG_CFG:  rd_mux = cfg_q[cfg_off[IDX_W-1:0]];
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  // R6: control address reads as zero
  a_r6_ctrl_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (kind == REG_CTRL) |=> (bus_rdata == '0));

  // R11: unmapped addresses read as zero
  a_r11_hole_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (kind == REG_NONE) |=> (bus_rdata == '0));

  // R11: a status read returns the pre-edge status word
  a_r11_stat_read: assert property (@(posedge clk) disable iff (rst)
    (kind == REG_STAT) |=> (bus_rdata == $past(stat_q)));

endmodule

// File: tb/tb_irq_agg_top.sv
module tb_irq_agg_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  hw_irq = '0;
  logic        gpio_irq = 1'b0;
  logic [7:0]  irq_out;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_agg_top dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_irq(hw_irq),
    .gpio_irq(gpio_irq), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input int a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_addr = 4'(a);
    @(negedge clk);
    d = bus_rdata;
  endtask

  function automatic logic [31:0] cfg_pat(input int j);
    return (32'h1 << j) | ((j % 2 == 1) ? 32'h8000 : 32'h0) | (32'h1 << (28 + (j % 4)));
  endfunction

  initial begin
    logic [31:0] v;
    logic [7:0]  e;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 irq_out", 32'(irq_out), 32'h0);
    chk("R1 rdata", bus_rdata, 32'h0);
    rd(1, v); chk("R1 status", v, 32'h0);
    for (int k = 0; k < 8; k++) begin
      rd(2 + k, v); chk("R1 cfg", v, 32'h0);
    end

    // R8: routing registers hold full words
    for (int k = 0; k < 8; k++) wr(2 + k, 32'hA5A5_0000 ^ (32'h1111_1111 * k));
    for (int k = 0; k < 8; k++) begin
      rd(2 + k, v); chk("R8 cfg readback", v, 32'hA5A5_0000 ^ (32'h1111_1111 * k));
    end
    // R11: holes read zero
    for (int a = 10; a < 16; a++) begin
      rd(a, v); chk("R11 hole", v, 32'h0);
    end
    for (int k = 0; k < 8; k++) wr(2 + k, 32'h0);

    // R2 / R3 / R4: each hardware bit latched and cleared
    for (int i = 0; i < 8; i++) begin
      hw_irq = 8'(1 << i);
      @(negedge clk);
      hw_irq = '0;
      repeat (2) @(negedge clk);
      rd(1, v); chk("R3 latched hw bit", v, 32'h1 << i);
      wr(1, 32'h0);
      rd(1, v); chk("R4 ack clears", v, 32'h0);
    end
    gpio_irq = 1'b1; @(negedge clk); gpio_irq = 1'b0;
    rd(1, v); chk("R2 gpio bit 15", v, 32'h8000);
    wr(1, 32'h0);

    // R7: everything driven, reserved bits stay zero
    hw_irq = 8'hFF; gpio_irq = 1'b1;
    wr(0, 32'hFFFF_FFFF);
    hw_irq = '0; gpio_irq = 1'b0;
    rd(1, v); chk("R7 reserved zero", v, 32'hF000_80FF);
    wr(1, 32'hFFFF_FFFF);
    rd(1, v); chk("R4 ones keep", v, 32'hF000_80FF);
    // R4: partial acknowledge
    wr(1, 32'h1000_0001);
    rd(1, v); chk("R4 partial ack", v, 32'h1000_0001);
    wr(1, 32'h0);

    // R6: software bits and control reads zero
    wr(0, 32'h0FFF_FFFF);
    rd(1, v); chk("R6 non-sw ctrl bits ignored", v, 32'h0);
    wr(0, 32'h5000_0000);
    rd(1, v); chk("R6 sw bits set", v, 32'h5000_0000);
    rd(0, v); chk("R6 ctrl reads zero", v, 32'h0);
    wr(1, 32'h0);

    // R5: ack during active level
    hw_irq = 8'h08;
    @(negedge clk);
    wr(1, 32'h0);
    rd(1, v); chk("R5 bit kept while high", v, 32'h8);
    hw_irq = '0;
    @(negedge clk);
    rd(1, v); chk("R5 bit latched after drop", v, 32'h8);
    wr(1, 32'h0);
    rd(1, v); chk("R5 cleared after drop", v, 32'h0);

    // R9: sweep of hardware and software patterns over eight masks
    for (int k = 0; k < 8; k++) wr(2 + k, cfg_pat(k));
    for (int s = 0; s < 256; s++) begin
      logic [31:0] st;
      logic [3:0]  p;
      p  = 4'(s) ^ 4'(s >> 4);
      st = 32'(s) | (32'(p) << 28);
      for (int j = 0; j < 8; j++) e[j] = |(st & cfg_pat(j));
      hw_irq = 8'(s);
      wr(0, 32'(p) << 28);
      hw_irq = '0;
      chk("R9 outputs same edge", 32'(irq_out), 32'(e));
      rd(1, v); chk("R9 status", v, st);
      wr(1, 32'h0);
      chk("R9 outputs after ack", 32'(irq_out), 32'h0);
    end

    // R10: mask removal while status stays set
    wr(2, 32'h1000_0000);
    wr(0, 32'h1000_0000);
    chk("R10 output on", 32'(irq_out[0]), 32'h1);
    wr(2, 32'h0);
    chk("R10 output off at mask write", 32'(irq_out[0]), 32'h0);
    rd(1, v); chk("R10 status still set", v, 32'h1000_0000);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule